// File: doc/BRIEF.md
# Ordered Speculative Store Buffers

This block holds the speculative stores of four cores that run consecutive pieces of one sequential program as speculative threads. Each core owns a private buffer of line-sized entries. An entry carries a line address, 32 data bytes and a per-byte valid mask. A store whose line is already buffered merges into that entry. A store to a new line takes a fresh entry. Nothing in a buffer reaches permanent state until its thread has finished and has become the oldest thread in program order.

An age table gives every core a rank from 0 (oldest, non-speculative) to 3 (most speculative). When the rank-0 core has raised `done`, its buffer drains onto a single commit write port, one entry per cycle, in the order the entries were allocated. After the last entry has been written, the table rotates. The finished core becomes the youngest and every other core moves one step older. This hands non-speculative status to the next thread, so commits follow the original thread order.

A dependence violation is handled by pulsing `squash` for the affected core. That empties its buffer and forgets its `done` at once. Permanent state is only ever written through the commit port, so discarding a buffer loses nothing that was already committed.

Top module: `spec_store_buffers`

## Requirements
- R1: After reset, core c holds rank c (the rank field of core c is `age_rank[2c+1:2c]`), every `st_ready` is 1 and `cm_valid` is 0.
- R2: A store accepted to a line not present in its core's buffer allocates a new entry. That entry later commits with the stored bytes where the mask bit is 1 and zero bytes elsewhere. Mask bit b covers data bits [8b+7:8b].
- R3: A store accepted to a line already present in its core's buffer updates only the masked bytes of that entry. The entry's mask becomes the OR of the old and new masks, and no new entry is used.
- R4: `st_ready` of a core is 1 only when that core has no pending `done`, its `squash` is low, and either its line is already buffered or fewer than DEPTH entries are in use. A store presented while `st_ready` is 0 is dropped.
- R5: A `done` pulse is remembered until that core's buffer has drained. Meanwhile the core's `st_ready` stays 0, and it returns to 1 once the drain completes.
- R6: `cm_valid` is 1 only for the rank-0 core after its `done` has been registered. Starting the cycle after `done` is sampled, it drives one entry per cycle in allocation order.
- R7: A core whose rank is not 0 never commits, even with `done` registered. Buffers therefore commit strictly in rank order.
- R8: One cycle after the rank-0 buffer has committed its last entry (or one cycle after `done` is registered, for an empty buffer), the ranks rotate. That core becomes rank 3 and every other rank drops by one.
- R9: `squash` empties the core's buffer and clears its pending `done` on that clock edge, with no commit traffic and no change to ranks. A store presented in the same cycle is refused (`st_ready` 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| st_valid | input | 4 | Per-core store request |
| st_addr | input | 64 | Per-core line address, 16 bits per core |
| st_data | input | 1024 | Per-core line data, 256 bits per core |
| st_mask | input | 128 | Per-core byte mask, 32 bits per core |
| st_ready | output | 4 | Per-core store acceptance |
| squash | input | 4 | Per-core buffer discard |
| done | input | 4 | Per-core thread-finished pulse |
| age_rank | output | 8 | Rank of each core, 2 bits per core |
| cm_valid | output | 1 | Commit write strobe |
| cm_addr | output | 16 | Commit line address |
| cm_data | output | 256 | Commit line data |
| cm_mask | output | 32 | Commit byte enables |

## Verification
The in-RTL assertions watch, every cycle, the invariants that do not depend on history:
- entry count and drain pointer stay within bounds;
- a finished core is stalled;
- a squash leaves an empty buffer with no pending `done`;
- exactly one core is oldest, and it changes whenever the table rotates;
- commits come only from a finished oldest core.

The bench's scenarios are what show byte-level merge contents, allocation-order draining, and the deferral of a finished younger thread behind an older one. They also cover the full-buffer stall against a hit that is still accepted, and the empty-buffer retire after a squash. Each scenario is compared cycle by cycle against a queue-based model.

// File: rtl/ssb_pkg.sv
package ssb_pkg;
  localparam int unsigned LINE_BYTES = 32;
  localparam int unsigned LINE_BITS  = LINE_BYTES * 8;

  typedef logic [LINE_BITS-1:0]  line_t;
  typedef logic [LINE_BYTES-1:0] bmask_t;

  // Replace the selected bytes of base with those of upd.
  function automatic line_t byte_merge(line_t base, line_t upd, bmask_t sel);
    line_t r;
    r = base;
    for (int b = 0; b < LINE_BYTES; b++) begin
      if (sel[b]) r[b*8 +: 8] = upd[b*8 +: 8];
    end
    return r;
  endfunction
endpackage

// File: rtl/ssb_core_buf.sv
module ssb_core_buf
  import ssb_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              st_valid,
  input  logic [ADDR_W-1:0] st_addr,
  input  line_t             st_data,
  input  bmask_t            st_mask,
  output logic              st_ready,
  input  logic              squash,
  input  logic              done,
  input  logic              is_oldest,
  output logic              head_valid,
  output logic [ADDR_W-1:0] head_addr,
  output line_t             head_data,
  output bmask_t            head_mask,
  output logic              retire
);
  localparam int unsigned CW = $clog2(DEPTH + 1);
  localparam int unsigned IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [ADDR_W-1:0] e_addr [DEPTH];
  line_t             e_data [DEPTH];
  bmask_t            e_mask [DEPTH];

  logic [CW-1:0] cnt_q, cnt_d, ptr_q, ptr_d;
  logic          done_q, done_d;

  logic [DEPTH-1:0] hit;
  logic             any_hit;
  logic [IW-1:0]    hit_idx, wr_idx;
  logic             accept, drain;
  logic [DEPTH-1:0] wr_en;
  line_t            wr_data;
  bmask_t           wr_mask;

  // Address match against the occupied entries only.
  always_comb begin
    hit     = '0;
    hit_idx = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if ((CW'(i) < cnt_q) && (e_addr[i] == st_addr)) begin
        hit[i]  = 1'b1;
        hit_idx = IW'(i);
      end
    end
  end

  assign any_hit  = |hit;
  assign st_ready = !squash && !done_q && (any_hit || (cnt_q < CW'(DEPTH)));
  assign accept   = st_valid && st_ready;

  always_comb begin
    wr_idx  = any_hit ? hit_idx : cnt_q[IW-1:0];
    wr_data = byte_merge(any_hit ? e_data[hit_idx] : '0, st_data, st_mask);
    wr_mask = (any_hit ? e_mask[hit_idx] : '0) | st_mask;
    for (int i = 0; i < DEPTH; i++) begin
      wr_en[i] = accept && (wr_idx == IW'(i));
    end
  end

  // Draining: only while finished and oldest.
  assign drain      = done_q && is_oldest && !squash;
  assign head_valid = drain && (ptr_q < cnt_q);
  assign retire     = drain && (ptr_q == cnt_q);
  assign head_addr  = e_addr[ptr_q[IW-1:0]];
  assign head_data  = e_data[ptr_q[IW-1:0]];
  assign head_mask  = e_mask[ptr_q[IW-1:0]];

  always_comb begin
    cnt_d  = cnt_q;
    ptr_d  = ptr_q;
    done_d = done_q;
    if (squash) begin
      cnt_d  = '0;
      ptr_d  = '0;
      done_d = 1'b0;
    end else begin
      if (accept && !any_hit) cnt_d = cnt_q + 1'b1;
      if (head_valid)         ptr_d = ptr_q + 1'b1;
      if (retire) begin
        cnt_d  = '0;
        ptr_d  = '0;
        done_d = 1'b0;
      end else if (done) begin
        done_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      ptr_q  <= '0;
      done_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      ptr_q  <= ptr_d;
      done_q <= done_d;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    always_ff @(posedge clk) begin
      if (wr_en[g]) begin
        e_addr[g] <= st_addr;
        e_data[g] <= wr_data;
        e_mask[g] <= wr_mask;
      end
    end
  end

  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));
  assert_ptr_in_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_q <= cnt_q);
  assert_stall_when_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> !st_ready);
  assert_squash_empties_R9: assert property (@(posedge clk) disable iff (!rst_n)
    squash |=> (cnt_q == '0) && !done_q);
endmodule

// File: rtl/ssb_rank_table.sv
module ssb_rank_table #(
  parameter  int unsigned NUM_CORES = 4,
  localparam int unsigned RW = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    advance,
  output logic [NUM_CORES-1:0]    oldest,
  output logic [NUM_CORES*RW-1:0] rank_flat
);
  logic [RW-1:0] rank_q [NUM_CORES];
  logic [RW-1:0] rank_d [NUM_CORES];

  always_comb begin
    for (int c = 0; c < NUM_CORES; c++) begin
      if (!advance)            rank_d[c] = rank_q[c];
      else if (rank_q[c] == '0) rank_d[c] = RW'(NUM_CORES - 1);
      else                     rank_d[c] = rank_q[c] - 1'b1;
      oldest[c]                = (rank_q[c] == '0);
      rank_flat[c*RW +: RW]    = rank_q[c];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < NUM_CORES; c++) rank_q[c] <= RW'(c);
    end else begin
      for (int c = 0; c < NUM_CORES; c++) rank_q[c] <= rank_d[c];
    end
  end

  assert_single_oldest_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(oldest) == 1);
  assert_rotation_moves_R8: assert property (@(posedge clk) disable iff (!rst_n)
    advance |=> oldest != $past(oldest));
endmodule

// File: rtl/ssb_commit_mux.sv
module ssb_commit_mux
  import ssb_pkg::*;
#(
  parameter int unsigned NUM_CORES = 4,
  parameter int unsigned ADDR_W    = 16
) (
  input  logic [NUM_CORES-1:0]            oldest,
  input  logic [NUM_CORES-1:0]            head_valid,
  input  logic [NUM_CORES*ADDR_W-1:0]     head_addr,
  input  logic [NUM_CORES*LINE_BITS-1:0]  head_data,
  input  logic [NUM_CORES*LINE_BYTES-1:0] head_mask,
  output logic                            cm_valid,
  output logic [ADDR_W-1:0]               cm_addr,
  output line_t                           cm_data,
  output bmask_t                          cm_mask
);
  always_comb begin
    cm_valid = 1'b0;
    cm_addr  = '0;
    cm_data  = '0;
    cm_mask  = '0;
    for (int c = 0; c < NUM_CORES; c++) begin
      if (oldest[c]) begin
        cm_valid = head_valid[c];
        cm_addr  = head_addr[c*ADDR_W +: ADDR_W];
        cm_data  = head_data[c*LINE_BITS +: LINE_BITS];
        cm_mask  = head_mask[c*LINE_BYTES +: LINE_BYTES];
      end
    end
  end
endmodule

// File: rtl/spec_store_buffers.sv
module spec_store_buffers
  import ssb_pkg::*;
#(
  parameter  int unsigned NUM_CORES = 4,
  parameter  int unsigned DEPTH     = 4,
  parameter  int unsigned ADDR_W    = 16,
  localparam int unsigned RW = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [NUM_CORES-1:0]            st_valid,
  input  logic [NUM_CORES*ADDR_W-1:0]     st_addr,
  input  logic [NUM_CORES*LINE_BITS-1:0]  st_data,
  input  logic [NUM_CORES*LINE_BYTES-1:0] st_mask,
  output logic [NUM_CORES-1:0]            st_ready,
  input  logic [NUM_CORES-1:0]            squash,
  input  logic [NUM_CORES-1:0]            done,
  output logic [NUM_CORES*RW-1:0]         age_rank,
  output logic                            cm_valid,
  output logic [ADDR_W-1:0]               cm_addr,
  output logic [LINE_BITS-1:0]            cm_data,
  output logic [LINE_BYTES-1:0]           cm_mask
);
  logic [NUM_CORES-1:0]            oldest, head_valid, retire;
  logic [NUM_CORES*ADDR_W-1:0]     head_addr;
  logic [NUM_CORES*LINE_BITS-1:0]  head_data;
  logic [NUM_CORES*LINE_BYTES-1:0] head_mask;

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
    ssb_core_buf #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_buf (
      .clk       (clk),
      .rst_n     (rst_n),
      .st_valid  (st_valid[c]),
      .st_addr   (st_addr[c*ADDR_W +: ADDR_W]),
      .st_data   (st_data[c*LINE_BITS +: LINE_BITS]),
      .st_mask   (st_mask[c*LINE_BYTES +: LINE_BYTES]),
      .st_ready  (st_ready[c]),
      .squash    (squash[c]),
      .done      (done[c]),
      .is_oldest (oldest[c]),
      .head_valid(head_valid[c]),
      .head_addr (head_addr[c*ADDR_W +: ADDR_W]),
      .head_data (head_data[c*LINE_BITS +: LINE_BITS]),
      .head_mask (head_mask[c*LINE_BYTES +: LINE_BYTES]),
      .retire    (retire[c])
    );
  end

  ssb_rank_table #(.NUM_CORES(NUM_CORES)) u_rank (
    .clk      (clk),
    .rst_n    (rst_n),
    .advance  (|retire),
    .oldest   (oldest),
    .rank_flat(age_rank)
  );

  ssb_commit_mux #(.NUM_CORES(NUM_CORES), .ADDR_W(ADDR_W)) u_mux (
    .oldest    (oldest),
    .head_valid(head_valid),
    .head_addr (head_addr),
    .head_data (head_data),
    .head_mask (head_mask),
    .cm_valid  (cm_valid),
    .cm_addr   (cm_addr),
    .cm_data   (cm_data),
    .cm_mask   (cm_mask)
  );

  // R6/R7: a commit always belongs to the oldest core, which is stalled.
  assert_commit_only_finished_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cm_valid |-> ((oldest & ~st_ready) == oldest));
endmodule

// File: tb/test_spec_store_buffers.sv
module test_spec_store_buffers;
  import ssb_pkg::*;
  localparam int NC = 4;
  localparam int DP = 4;
  localparam int AW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NC-1:0]            st_valid = '0;
  logic [NC*AW-1:0]         st_addr = '0;
  logic [NC*LINE_BITS-1:0]  st_data = '0;
  logic [NC*LINE_BYTES-1:0] st_mask = '0;
  logic [NC-1:0]            squash = '0, done = '0;
  logic [NC-1:0]            st_ready;
  logic [NC*2-1:0]          age_rank;
  logic                     cm_valid;
  logic [AW-1:0]            cm_addr;
  line_t                    cm_data;
  bmask_t                   cm_mask;

  int nchk = 0, nfail = 0;

  always #5 clk = ~clk;

  spec_store_buffers #(.NUM_CORES(NC), .DEPTH(DP), .ADDR_W(AW)) i_spec_store_buffers (
    .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_addr(st_addr), .st_data(st_data),
    .st_mask(st_mask), .st_ready(st_ready), .squash(squash), .done(done),
    .age_rank(age_rank), .cm_valid(cm_valid), .cm_addr(cm_addr), .cm_data(cm_data),
    .cm_mask(cm_mask));

  // Behavioural reference model
  logic [AW-1:0] qa [NC][$];
  line_t         qd [NC][$];
  bmask_t        qm [NC][$];
  int            mptr [NC];
  bit            mdone [NC];
  int            mrank [NC];

  // DUT commit log
  logic [AW-1:0] la [$];
  line_t         ld [$];
  bmask_t        lm [$];

  task automatic chk(bit ok, string req, logic [LINE_BITS-1:0] act, logic [LINE_BITS-1:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic line_t pat(int c, int k);
    line_t r;
    for (int b = 0; b < LINE_BYTES; b++) r[b*8 +: 8] = 8'((c*71 + k*29 + b*5 + 3) & 255);
    return r;
  endfunction

  function automatic line_t mmerge(line_t base, line_t upd, bmask_t m);
    line_t r;
    for (int b = 0; b < LINE_BYTES; b++) r[b*8 +: 8] = m[b] ? upd[b*8 +: 8] : base[b*8 +: 8];
    return r;
  endfunction

  function automatic int find(int c, logic [AW-1:0] a);
    for (int i = 0; i < qa[c].size(); i++) if (qa[c][i] == a) return i;
    return -1;
  endfunction

  task automatic set_st(int c, logic [AW-1:0] a, line_t d, bmask_t m);
    st_valid[c] = 1'b1;
    st_addr[c*AW +: AW] = a;
    st_data[c*LINE_BITS +: LINE_BITS] = d;
    st_mask[c*LINE_BYTES +: LINE_BYTES] = m;
  endtask

  task automatic idle();
    st_valid = '0; squash = '0; done = '0;
  endtask

  // One cycle: compare against model, advance model, move to next falling edge.
  task automatic step();
    bit pr [NC];
    int old, k;
    bit pv, ret;
    #1;
    old = 0;
    for (int c = 0; c < NC; c++) if (mrank[c] == 0) old = c;
    for (int c = 0; c < NC; c++) begin
      pr[c] = !squash[c] && !mdone[c] &&
              (find(c, st_addr[c*AW +: AW]) >= 0 || qa[c].size() < DP);
      chk(st_ready[c] == pr[c], "R4 st_ready", LINE_BITS'(st_ready[c]), LINE_BITS'(pr[c]));
      chk(age_rank[c*2 +: 2] == 2'(mrank[c]), "R8 rank",
          LINE_BITS'(age_rank[c*2 +: 2]), LINE_BITS'(mrank[c]));
    end
    pv  = mdone[old] && !squash[old] && (mptr[old] < qa[old].size());
    ret = mdone[old] && !squash[old] && (mptr[old] == qa[old].size());
    chk(cm_valid == pv, "R6 cm_valid", LINE_BITS'(cm_valid), LINE_BITS'(pv));
    if (pv && cm_valid) begin
      chk(cm_addr == qa[old][mptr[old]], "R6 cm_addr", LINE_BITS'(cm_addr), LINE_BITS'(qa[old][mptr[old]]));
      chk(cm_data == qd[old][mptr[old]], "R2 cm_data", cm_data, qd[old][mptr[old]]);
      chk(cm_mask == qm[old][mptr[old]], "R3 cm_mask", LINE_BITS'(cm_mask), LINE_BITS'(qm[old][mptr[old]]));
    end
    if (cm_valid) begin
      la.push_back(cm_addr); ld.push_back(cm_data); lm.push_back(cm_mask);
    end
    for (int c = 0; c < NC; c++) begin
      if (squash[c]) begin
        qa[c].delete(); qd[c].delete(); qm[c].delete();
        mptr[c] = 0; mdone[c] = 0;
      end else begin
        if (st_valid[c] && pr[c]) begin
          k = find(c, st_addr[c*AW +: AW]);
          if (k >= 0) begin
            qd[c][k] = mmerge(qd[c][k], st_data[c*LINE_BITS +: LINE_BITS], st_mask[c*LINE_BYTES +: LINE_BYTES]);
            qm[c][k] = qm[c][k] | st_mask[c*LINE_BYTES +: LINE_BYTES];
          end else begin
            qa[c].push_back(st_addr[c*AW +: AW]);
            qd[c].push_back(mmerge('0, st_data[c*LINE_BITS +: LINE_BITS], st_mask[c*LINE_BYTES +: LINE_BYTES]));
            qm[c].push_back(st_mask[c*LINE_BYTES +: LINE_BYTES]);
          end
        end
        if (c == old && pv) mptr[c]++;
        if (c == old && ret) begin
          qa[c].delete(); qd[c].delete(); qm[c].delete();
          mptr[c] = 0; mdone[c] = 0;
        end else if (done[c]) mdone[c] = 1;
      end
    end
    if (ret) for (int c = 0; c < NC; c++) mrank[c] = (mrank[c] == 0) ? NC - 1 : mrank[c] - 1;
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    line_t exp_m;
    for (int c = 0; c < NC; c++) begin mptr[c] = 0; mdone[c] = 0; mrank[c] = c; end
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    #1;
    chk(age_rank == 8'hE4, "R1 ranks", LINE_BITS'(age_rank), LINE_BITS'(8'hE4));
    chk(st_ready == 4'hF, "R1 ready", LINE_BITS'(st_ready), LINE_BITS'(4'hF));
    chk(cm_valid == 1'b0, "R1 cm_valid", LINE_BITS'(cm_valid), '0);
    step();

    // R2/R3: allocate, merge; R7: younger finished thread waits
    set_st(0, 16'h0010, pat(0, 1), 32'h0000FFFF); step();
    set_st(0, 16'h0020, pat(0, 2), 32'hFFFFFFFF); step();
    set_st(0, 16'h0010, pat(0, 3), 32'h00FF00F0); step();
    idle(); set_st(1, 16'h0010, pat(1, 1), 32'hFFFFFFFF); step();
    idle(); done[1] = 1'b1; step();
    idle(); repeat (3) step();
    chk(la.size() == 0, "R7 no early commit", LINE_BITS'(la.size()), '0);
    done[0] = 1'b1; step();
    idle(); repeat (6) step();
    chk(la.size() == 3, "R6 commit count", LINE_BITS'(la.size()), LINE_BITS'(3));
    if (la.size() == 3) begin
      exp_m = mmerge(mmerge('0, pat(0, 1), 32'h0000FFFF), pat(0, 3), 32'h00FF00F0);
      chk(la[0] == 16'h0010, "R6 first addr", LINE_BITS'(la[0]), LINE_BITS'(16'h0010));
      chk(ld[0] == exp_m, "R3 merged data", ld[0], exp_m);
      chk(lm[0] == 32'h00FFFFFF, "R3 merged mask", LINE_BITS'(lm[0]), LINE_BITS'(32'h00FFFFFF));
      chk(la[1] == 16'h0020 && ld[1] == pat(0, 2), "R2 second entry", ld[1], pat(0, 2));
      chk(ld[2] == pat(1, 1), "R7 younger commits after older", ld[2], pat(1, 1));
    end
    #1;
    chk(age_rank == 8'h4E, "R8 rotated ranks", LINE_BITS'(age_rank), LINE_BITS'(8'h4E));

    // R4: full buffer on core 2 (now oldest)
    for (int i = 0; i < DP; i++) begin
      idle(); set_st(2, 16'h0100 + 16'(i), pat(2, i), 32'hFFFFFFFF); step();
    end
    idle(); set_st(2, 16'h0200, pat(2, 9), 32'hFFFFFFFF);
    #1;
    chk(st_ready[2] == 1'b0, "R4 full stall", LINE_BITS'(st_ready[2]), '0);
    step();
    idle(); set_st(2, 16'h0101, pat(2, 7), 32'h0000000F);
    #1;
    chk(st_ready[2] == 1'b1, "R4 hit while full", LINE_BITS'(st_ready[2]), LINE_BITS'(1));
    step();

    // R9: squash empties, then empty drain rotates (R8)
    idle(); squash[2] = 1'b1; step();
    idle();
    #1;
    chk(st_ready[2] == 1'b1, "R9 emptied", LINE_BITS'(st_ready[2]), LINE_BITS'(1));
    done[2] = 1'b1; step();
    idle(); repeat (3) step();
    chk(la.size() == 3, "R9 nothing committed", LINE_BITS'(la.size()), LINE_BITS'(3));
    #1;
    chk(age_rank == 8'h39, "R8 empty retire", LINE_BITS'(age_rank), LINE_BITS'(8'h39));

    // R9: squash beats a concurrent store
    set_st(1, 16'h0300, pat(1, 5), 32'hFFFFFFFF); squash[1] = 1'b1;
    #1;
    chk(st_ready[1] == 1'b0, "R9 store refused", LINE_BITS'(st_ready[1]), '0);
    step();
    idle(); step();

    // R5: stall after done; R7 ordering between core 3 and core 0
    set_st(0, 16'h0040, pat(0, 6), 32'hFFFF0000); step();
    idle(); done[0] = 1'b1; step();
    idle(); set_st(0, 16'h0041, pat(0, 8), 32'hFFFFFFFF);
    #1;
    chk(st_ready[0] == 1'b0, "R5 stalled after done", LINE_BITS'(st_ready[0]), '0);
    step();
    idle(); set_st(3, 16'h0050, pat(3, 1), 32'h000000FF); step();
    idle(); done[3] = 1'b1; step();
    idle(); repeat (8) step();
    chk(la.size() == 5, "R6 total commits", LINE_BITS'(la.size()), LINE_BITS'(5));
    if (la.size() == 5) begin
      chk(la[3] == 16'h0050, "R7 oldest first", LINE_BITS'(la[3]), LINE_BITS'(16'h0050));
      chk(la[4] == 16'h0040, "R6 next thread", LINE_BITS'(la[4]), LINE_BITS'(16'h0040));
    end
    #1;
    chk(st_ready[0] == 1'b1, "R5 ready after drain", LINE_BITS'(st_ready[0]), LINE_BITS'(1));

    $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule